// File: doc/BRIEF.md
# Serial ADC host controller

This block sequences an eight-channel successive-approximation converter from the host side. The converter has a three-wire full-duplex serial port, a conversion-start strobe, an active-low read enable and a ready line that reads high when the converter is idle. For each accepted request the block raises the start strobe for a fixed minimum width. It then waits for the ready line, opens the read window and clocks sixteen serial bits. During those sixteen bits it shifts the request's 8-bit configuration word out and shifts the 16-bit result of the conversion that just finished in.

The converter applies a configuration word to the conversion that follows the transfer carrying it. The result that arrives in a transfer therefore belongs to the word sent in the transfer before it. The block keeps a one-entry tag of the last word it sent and labels every result with that word's channel and range fields. The first result after reset comes from a conversion that no word of this block set up, and the block flags it as stale. Converters narrower than sixteen bits pad their result with trailing zeros, and the block drops those bits. A conversion that does not finish within a bound raises a timeout, and no transfer follows it.

Top module: `adcq_host`

## Requirements
- R1: After reset, `adc_convst`=0, `adc_rd_n`=1, `adc_sck`=0, `res_valid`=0 and `err_timeout`=0, and `req_ready` equals `adc_ready`.
- R2: A request is accepted only when the block is idle and `adc_ready`=1 (`req_ready` is high exactly then). `adc_convst` rises on the clock edge that accepts the request.
- R3: `adc_convst` stays high for exactly ceil(CLK_HZ x START_NS / 1e9) clock cycles, with a minimum of one cycle.
- R4: `adc_rd_n` falls only after `adc_ready` has been seen high following the start pulse. `adc_convst` and a low `adc_rd_n` never occur together.
- R5: `adc_sck` idles low. Each read window carries exactly 16 SCK pulses, and each high level and each low level between pulses lasts SCK_HALF clock cycles.
- R6: `adc_sdi` changes only while `adc_sck` is low. The first eight bits sampled on rising SCK edges are `req_cfg[7]` down to `req_cfg[0]`, and the last eight bits are zero. Field layout: bit7 single-ended, bit6 odd/sign, bits5:4 select, bit3 unipolar, bit2 gain, bit1 nap, bit0 sleep.
- R7: `adc_sdo` is sampled on each rising SCK edge, MSB first. `res_data` is the top RES_W bits of the 16 received bits, and the trailing 16-RES_W bits are dropped.
- R8: `res_valid` is a single-cycle pulse in the cycle the transfer ends, and `adc_rd_n` is already high in that cycle.
- R9: `res_chan` = {bit7, bit6, bit5, bit4} and `res_range` = {bit3, bit2} of the configuration word sent in the previous completed transfer.
- R10: The first result after each reset has `res_stale`=1, and every later result has `res_stale`=0.
- R11: If `adc_ready` is not high within TMO_CYC cycles after `adc_convst` falls, `err_timeout` pulses for one cycle exactly TMO_CYC cycles after the fall. No read window follows, the request is dropped, and the tag is kept, so the next result carries the last configuration word actually sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Conversion request |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_cfg | input | 8 | Configuration word for the request |
| adc_convst | output | 1 | Conversion-start strobe |
| adc_rd_n | output | 1 | Read enable, active low |
| adc_ready | input | 1 | Converter idle (low while converting) |
| adc_sck | output | 1 | Serial clock |
| adc_sdi | output | 1 | Serial data to converter |
| adc_sdo | input | 1 | Serial data from converter |
| res_valid | output | 1 | Result strobe |
| res_data | output | RES_W | Conversion result, padding removed |
| res_chan | output | 4 | Mux address of the word that set up this result |
| res_range | output | 2 | Unipolar and gain bits of that word |
| res_stale | output | 1 | Result was not set up by this block |
| err_timeout | output | 1 | Converter did not finish in time |

## Verification
The bench sweeps all 256 configuration words in a scrambled order with varying conversion lengths. A design that tagged results with the current word instead of the previous one would fail on every transfer after the first. A design that sliced the wrong end of the padded 12-bit result would return shifted values. The bench resets a second time in the middle of the run, so a stale flag that is not rearmed is caught. It also forces a conversion past the timeout bound: a design that still opened a read window, advanced its tag or accepted a request while the converter was busy would mislabel the recovery result or break the start-pulse rules.

// File: rtl/adcq_pkg.sv
package adcq_pkg;

    localparam int XFER_BITS = 16;
    localparam int CFG_BITS  = 8;
    localparam int TAG_BITS  = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_WAIT,
        ST_RDSET,
        ST_XFER
    } state_e;

    // shift order: single is sent first
    typedef struct packed {
        logic       single;
        logic       odd;
        logic [1:0] sel;
        logic       uni;
        logic       gain;
        logic       nap;
        logic       sleep;
    } cfg_t;

endpackage

// File: rtl/adcq_sck_gen.sv
module adcq_sck_gen #(
    parameter int HALF  = 4,
    parameter int NBITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic sck_o,
    output logic rise_o,
    output logic fall_o,
    output logic last_o,
    output logic busy_o
);
    localparam int PH_W  = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BIT_W = $clog2(NBITS);

    typedef struct packed {
        logic             act;
        logic             hi;
        logic [PH_W-1:0]  ph;
        logic [BIT_W-1:0] bits;
    } gen_t;

    gen_t gen_d, gen_q;
    logic wrap;

    always_comb begin
        wrap   = (gen_q.ph == PH_W'(HALF - 1));
        rise_o = gen_q.act && !gen_q.hi && wrap;
        fall_o = gen_q.act &&  gen_q.hi && wrap;
        last_o = fall_o && (gen_q.bits == BIT_W'(NBITS - 1));
        gen_d  = gen_q;
        if (start_i) begin
            gen_d.act  = 1'b1;
            gen_d.hi   = 1'b0;
            gen_d.ph   = '0;
            gen_d.bits = '0;
        end else if (gen_q.act) begin
            if (wrap) begin
                gen_d.ph = '0;
                gen_d.hi = !gen_q.hi;
                if (fall_o) begin
                    if (last_o) gen_d.act  = 1'b0;
                    else        gen_d.bits = gen_q.bits + 1'b1;
                end
            end else begin
                gen_d.ph = gen_q.ph + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign sck_o  = gen_q.hi;
    assign busy_o = gen_q.act;

    // R5
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (busy_o && !sck_o));

endmodule

// File: rtl/adcq_shifter.sv
module adcq_shifter #(
    parameter int NBITS = 16,
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             tx_step_i,
    input  logic             rx_step_i,
    input  logic             sdo_i,
    output logic             sdi_o,
    output logic [NBITS-1:0] rx_o
);
    localparam int FILL = NBITS - CFG_W;

    typedef struct packed {
        logic [NBITS-1:0] tx;
        logic [NBITS-1:0] rx;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d.tx = {cfg_i, {FILL{1'b0}}};
            sh_d.rx = '0;
        end else begin
            if (tx_step_i) sh_d.tx = {sh_q.tx[NBITS-2:0], 1'b0};
            if (rx_step_i) sh_d.rx = {sh_q.rx[NBITS-2:0], sdo_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sdi_o = sh_q.tx[NBITS-1];
    assign rx_o  = sh_q.rx;

    // R6
    load_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (sdi_o == $past(cfg_i[CFG_W-1])));

endmodule

// File: rtl/adcq_tag.sv
module adcq_tag #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         commit_i,
    input  logic [W-1:0] cfg_i,
    output logic [W-1:0] tag_o,
    output logic         seen_o
);
    typedef struct packed {
        logic         seen;
        logic [W-1:0] tag;
    } tag_t;

    tag_t tg_d, tg_q;

    always_comb begin
        tg_d = tg_q;
        if (commit_i) begin
            tg_d.tag  = cfg_i;
            tg_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tg_q <= '0;
        else        tg_q <= tg_d;
    end

    assign tag_o  = tg_q.tag;
    assign seen_o = tg_q.seen;

    // R10
    seen_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> seen_o);

    // R11
    tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(tag_o));

endmodule

// File: rtl/adcq_host.sv
module adcq_host
    import adcq_pkg::*;
#(
    parameter int CLK_HZ   = 100_000_000,
    parameter int START_NS = 40,
    parameter int SCK_HALF = 4,
    parameter int RES_W    = 16,
    parameter int TMO_CYC  = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [7:0]       req_cfg,
    output logic             adc_convst,
    output logic             adc_rd_n,
    input  logic             adc_ready,
    output logic             adc_sck,
    output logic             adc_sdi,
    input  logic             adc_sdo,
    output logic             res_valid,
    output logic [RES_W-1:0] res_data,
    output logic [3:0]       res_chan,
    output logic [1:0]       res_range,
    output logic             res_stale,
    output logic             err_timeout
);
    localparam int START_RAW = ((CLK_HZ / 1000) * START_NS + 999_999) / 1_000_000;
    localparam int START_CYC = (START_RAW < 1) ? 1 : START_RAW;
    localparam int CNT_MAX   = (START_CYC > TMO_CYC) ? START_CYC : TMO_CYC;
    localparam int CNT_W     = $clog2(CNT_MAX + 1);
    localparam int PAD       = XFER_BITS - RES_W;
    localparam int LEN_W     = $clog2(START_CYC + 2) + 1;

    typedef struct packed {
        state_e                st;
        logic [CNT_W-1:0]      cnt;
        cfg_t                  cfg;
        logic                  convst;
        logic                  rd_n;
        logic                  rv;
        logic [RES_W-1:0]      rdata;
        logic [TAG_BITS-1:0]   rtag;
        logic                  rstale;
        logic                  err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                 sck_start, sh_load, tag_commit;
    logic                 g_rise, g_fall, g_last, g_busy, g_sck;
    logic                 sh_sdi;
    logic [XFER_BITS-1:0] rx_word;
    logic [TAG_BITS-1:0]  tag_val;
    logic                 tag_seen;

    adcq_sck_gen #(.HALF(SCK_HALF), .NBITS(XFER_BITS)) sck_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (sck_start),
        .sck_o   (g_sck),
        .rise_o  (g_rise),
        .fall_o  (g_fall),
        .last_o  (g_last),
        .busy_o  (g_busy)
    );

    adcq_shifter #(.NBITS(XFER_BITS), .CFG_W(CFG_BITS)) shf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (sh_load),
        .cfg_i     (ctl_q.cfg),
        .tx_step_i (g_fall),
        .rx_step_i (g_rise),
        .sdo_i     (adc_sdo),
        .sdi_o     (sh_sdi),
        .rx_o      (rx_word)
    );

    adcq_tag #(.W(TAG_BITS)) tag_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (tag_commit),
        .cfg_i    (ctl_q.cfg[CFG_BITS-1 -: TAG_BITS]),
        .tag_o    (tag_val),
        .seen_o   (tag_seen)
    );

    generate
        if (PAD > 0) begin : g_pad
            logic pad_unused;
            assign pad_unused = ^rx_word[PAD-1:0];
        end
    endgenerate

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.rv   = 1'b0;
        ctl_d.err  = 1'b0;
        sck_start  = 1'b0;
        sh_load    = 1'b0;
        tag_commit = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid && adc_ready) begin
                    ctl_d.cfg    = cfg_t'(req_cfg);
                    ctl_d.st     = ST_START;
                    ctl_d.convst = 1'b1;
                    ctl_d.cnt    = '0;
                end
            end
            ST_START: begin
                if (ctl_q.cnt == CNT_W'(START_CYC - 1)) begin
                    ctl_d.convst = 1'b0;
                    ctl_d.st     = ST_WAIT;
                    ctl_d.cnt    = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_WAIT: begin
                if (adc_ready) begin
                    ctl_d.st   = ST_RDSET;
                    ctl_d.rd_n = 1'b0;
                    sh_load    = 1'b1;
                end else if (ctl_q.cnt == CNT_W'(TMO_CYC - 1)) begin
                    ctl_d.err = 1'b1;
                    ctl_d.st  = ST_IDLE;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_RDSET: begin
                sck_start = 1'b1;
                ctl_d.st  = ST_XFER;
            end
            ST_XFER: begin
                if (g_last) begin
                    ctl_d.rd_n   = 1'b1;
                    ctl_d.rv     = 1'b1;
                    ctl_d.rdata  = rx_word[XFER_BITS-1 -: RES_W];
                    ctl_d.rtag   = tag_val;
                    ctl_d.rstale = !tag_seen;
                    tag_commit   = 1'b1;
                    ctl_d.st     = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_IDLE;
            ctl_q.rd_n <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready   = (ctl_q.st == ST_IDLE) && adc_ready;
    assign adc_convst  = ctl_q.convst;
    assign adc_rd_n    = ctl_q.rd_n;
    assign adc_sck     = g_sck;
    assign adc_sdi     = sh_sdi;
    assign res_valid   = ctl_q.rv;
    assign res_data    = ctl_q.rdata;
    assign res_chan    = ctl_q.rtag[TAG_BITS-1 -: 4];
    assign res_range   = ctl_q.rtag[1:0];
    assign res_stale   = ctl_q.rstale;
    assign err_timeout = ctl_q.err;

    // checker-side width counter for the start strobe
    logic [LEN_W-1:0] cv_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cv_len_q <= '0;
        else if (!adc_convst) cv_len_q <= '0;
        else if (cv_len_q != {LEN_W{1'b1}}) cv_len_q <= cv_len_q + 1'b1;
    end

    // R3
    convst_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_convst) |-> (cv_len_q >= LEN_W'(START_CYC)));

    // R2
    start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_convst) |-> $past(adc_ready));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_convst |-> adc_rd_n);

    // R5
    sck_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_sck |-> !adc_rd_n);

    // R5
    gen_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st != ST_XFER) |-> !g_busy);

    // R6
    sdi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_sck |-> $stable(adc_sdi));

    // R8
    result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R8
    result_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> adc_rd_n);

    // R11
    timeout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> (adc_rd_n && !res_valid && !$past(adc_ready)));

endmodule

// File: tb/adcq_host_tb_top.sv
module adcq_host_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 100_000_000;
    localparam int START_NS   = 40;
    localparam int HALF       = 2;
    localparam int RES_W      = 12;
    localparam int TMO        = 64;
    localparam int EXP_START  = ((CLK_HZ / 1_000_000) * START_NS + 999) / 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [7:0] req_cfg = 8'h00;
    logic adc_ready = 1'b1;
    logic adc_sdo;
    logic req_ready, adc_convst, adc_rd_n, adc_sck, adc_sdi;
    logic res_valid, res_stale, err_timeout;
    logic [RES_W-1:0] res_data;
    logic [3:0] res_chan;
    logic [1:0] res_range;

    adcq_host #(
        .CLK_HZ(CLK_HZ), .START_NS(START_NS), .SCK_HALF(HALF),
        .RES_W(RES_W), .TMO_CYC(TMO)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_cfg(req_cfg),
        .adc_convst(adc_convst), .adc_rd_n(adc_rd_n), .adc_ready(adc_ready),
        .adc_sck(adc_sck), .adc_sdi(adc_sdi), .adc_sdo(adc_sdo),
        .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan),
        .res_range(res_range), .res_stale(res_stale), .err_timeout(err_timeout)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] mkval(input int idx, input logic [7:0] c);
        return 12'((idx * 291 + int'(c) * 13 + 5) % 4096);
    endfunction

    // converter model
    int conv_len = 8;
    int conv_left = 0;
    int n_conv = 0;
    int dev_bits = 0;
    logic [7:0]  dev_cfg = 8'h00;
    logic [15:0] dev_res = '0;
    logic [15:0] dev_sh = '0;
    logic [15:0] dev_in = '0;
    logic [7:0]  got_cfg = '0;
    logic [7:0]  got_tail = '0;
    logic cv_prev = 1'b0, rd_prev = 1'b1, sck_prev = 1'b0;

    assign adc_sdo = dev_sh[15];

    always @(posedge clk) begin
        cv_prev  <= adc_convst;
        rd_prev  <= adc_rd_n;
        sck_prev <= adc_sck;
        if (adc_convst && !cv_prev) begin
            dev_res   <= {mkval(n_conv, dev_cfg), 4'h0};
            n_conv    <= n_conv + 1;
            conv_left <= conv_len;
            adc_ready <= 1'b0;
        end else if (conv_left > 1) begin
            conv_left <= conv_left - 1;
        end else if (conv_left == 1) begin
            conv_left <= 0;
            adc_ready <= 1'b1;
        end
        if (!adc_rd_n && rd_prev) begin
            dev_sh   <= dev_res;
            dev_bits <= 0;
        end else if (!adc_sck && sck_prev) begin
            dev_sh <= {dev_sh[14:0], 1'b0};
        end
        if (adc_sck && !sck_prev) begin
            dev_in   <= {dev_in[14:0], adc_sdi};
            dev_bits <= dev_bits + 1;
        end
        if (adc_rd_n && !rd_prev && dev_bits == 16) begin
            dev_cfg  <= dev_in[15:8];
            got_cfg  <= dev_in[15:8];
            got_tail <= dev_in[7:0];
        end
    end

    // port monitor for strobe width, read ordering and SCK shape
    int cv_hi = 0, hi_c = 0, lo_c = 0, rises = 0;
    logic m_cv = 1'b0, m_rd = 1'b1, m_sck = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (adc_convst) cv_hi++;
            else if (m_cv) begin
                chk(cv_hi == EXP_START, "R3 start width", cv_hi, EXP_START);
                cv_hi = 0;
            end
            if (!adc_rd_n) chk(!adc_convst, "R4 start during read", adc_convst, 0);
            if (!adc_rd_n && m_rd) begin
                chk(adc_ready, "R4 read before ready", adc_ready, 1);
                rises = 0;
            end
            if (adc_rd_n && !m_rd) chk(rises == 16, "R5 pulse count", rises, 16);
            if (adc_sck && !m_sck) begin
                if (rises > 0) chk(lo_c == HALF, "R5 low width", lo_c, HALF);
                rises++;
                hi_c = 1;
            end else if (adc_sck) begin
                hi_c++;
            end else if (m_sck) begin
                chk(hi_c == HALF, "R5 high width", hi_c, HALF);
                lo_c = 1;
            end else begin
                lo_c++;
            end
            m_cv  = adc_convst;
            m_rd  = adc_rd_n;
            m_sck = adc_sck;
        end
    end

    logic [7:0] prev_cfg = 8'h00;
    bit first = 1'b1;

    task automatic run_req(input logic [7:0] c, input bit want_tmo);
        int n;
        bit saw_rd;
        n = 0;
        while (!req_ready && n < 2000) begin
            @(negedge clk);
            n++;
        end
        req_valid = 1'b1;
        req_cfg   = c;
        @(negedge clk);
        req_valid = 1'b0;
        chk(adc_convst == 1'b1, "R2 start after accept", adc_convst, 1);
        if (want_tmo) begin
            while (adc_convst) @(negedge clk);
            n = 0;
            saw_rd = 1'b0;
            while (!err_timeout && n < 1000) begin
                @(negedge clk);
                n++;
                if (!adc_rd_n || res_valid) saw_rd = 1'b1;
            end
            chk(n == TMO, "R11 timeout cycle", n, TMO);
            chk(!saw_rd, "R11 no read window", saw_rd, 0);
            @(negedge clk);
            chk(err_timeout == 1'b0, "R11 one-cycle error", err_timeout, 0);
            chk(req_ready == 1'b0, "R2 blocked while converting", req_ready, 0);
        end else begin
            n = 0;
            while (!res_valid && !err_timeout && n < 2000) begin
                @(negedge clk);
                n++;
            end
            chk(res_valid, "R8 result arrives", res_valid, 1);
            chk(adc_rd_n, "R8 read released", adc_rd_n, 1);
            chk(res_data == mkval(n_conv - 1, prev_cfg), "R7 data",
                32'(res_data), 32'(mkval(n_conv - 1, prev_cfg)));
            chk(res_stale == first, "R10 stale flag", res_stale, first);
            if (!first) begin
                chk(res_chan == prev_cfg[7:4], "R9 channel tag", res_chan, prev_cfg[7:4]);
                chk(res_range == prev_cfg[3:2], "R9 range tag", res_range, prev_cfg[3:2]);
            end
            @(negedge clk);
            chk(res_valid == 1'b0, "R8 single pulse", res_valid, 0);
            chk(got_cfg == c, "R6 config bits", got_cfg, c);
            chk(got_tail == 8'h00, "R6 trailing zeros", got_tail, 0);
            prev_cfg = c;
            first    = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(adc_convst == 1'b0, "R1 convst", adc_convst, 0);
        chk(adc_rd_n == 1'b1, "R1 rd_n", adc_rd_n, 1);
        chk(adc_sck == 1'b0, "R1 sck", adc_sck, 0);
        chk(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
        chk(err_timeout == 1'b0, "R1 err", err_timeout, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready follows converter", req_ready, 1);

        for (int i = 0; i < 256; i++) begin
            conv_len = 6 + (i % 9);
            run_req(8'(i * 37 + 11), 1'b0);
        end

        conv_len = TMO + 40;
        run_req(8'hA5, 1'b1);
        conv_len = 7;
        run_req(8'h3C, 1'b0);

        // second reset: stale flag rearms (R10)
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(res_stale == 1'b0 && adc_rd_n == 1'b1, "R1 reset again", adc_rd_n, 1);
        rst_n = 1'b1;
        first = 1'b1;
        @(negedge clk);
        run_req(8'h96, 1'b0);
        run_req(8'h0F, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule